// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip host and an external byte-wide asynchronous static RAM with 17 address bits. The host hands over one word at a time through a valid/ready request port: a write carries an address and a data byte, and a read carries an address whose byte comes back later as a one-cycle result pulse. The controller turns each request into a timed sequence on the RAM pins: an active-low chip select, an active-high second chip select, an active-low write strobe, an active-low output enable, and a data bus that is split into separate out, out-enable and in signals.

Every hold time is a cycle count worked out at elaboration from the clock period in nanoseconds and a speed-grade number (0, 1 or 2 for RAM access times of 35, 55 or 70 ns). Each count is the nanosecond limit divided by the period, rounded up, with a minimum of one. Between requests the RAM is deselected and kept in standby, and the controller reports ready. A write never drives the bus while the RAM might still be driving it from a preceding read.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and just after it, ram_ce_n is 1, ram_ce2 is 0, ram_we_n is 1, ram_oe_n is 1, ram_dq_oe is 0, rd_valid is 0 and req_ready is 0. req_ready rises once the synchronised reset has released.
- R2: req_ready is 1 only while the controller is idle. Whenever it is 1, the RAM is deselected (ram_ce_n=1, ram_ce2=0), ram_we_n and ram_oe_n are 1 and the bus is released. ram_ce2 is always the inverse of ram_ce_n.
- R3: A read holds ram_ce_n=0, ram_ce2=1, ram_we_n=1 and ram_oe_n=0 for exactly ceil(tAA/period) cycles (minimum 1), where tAA is 35, 55 or 70 ns for grades 0, 1 or 2.
- R4: The read byte is sampled from ram_dq_in on the clock edge that ends the read, which is the same edge on which ram_oe_n returns high. rd_valid is then 1 for exactly one cycle with that byte on rd_data.
- R5: A write holds ram_ce_n=0 and ram_ce2=1. ram_we_n stays low for at least ceil(tWP/period) cycles, where tWP is 25, 45 or 55 ns for grades 0, 1 or 2.
- R6: ram_addr does not change while the RAM is selected, and in particular never while ram_we_n is low.
- R7: ram_dq_oe is 1 only while ram_we_n is low, and never in the first cycle of the strobe. It falls on the same edge as ram_we_n rises, and it stays high for at least ceil(tDW/period) cycles, where tDW is 20, 25 or 30 ns for grades 0, 1 or 2.
- R8: ram_oe_n is 1 whenever ram_we_n is 0.
- R9: After ram_oe_n rises at the end of a read, ram_dq_oe does not rise until at least ceil(tHZ/period) cycles later, where tHZ is 15, 20 or 25 ns for grades 0, 1 or 2. If that wait has not run out, the write strobe is stretched.
- R10: A request is taken on a clock edge where req_valid and req_ready are both 1. The address, direction and write data are captured on that edge, and later changes on the request inputs have no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, will take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse, read data present |
| rd_data | output | 8 | Read data |
| ram_addr | output | 17 | RAM address pins |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_ce2 | output | 1 | RAM second chip select, active high |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 8 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |
| ram_dq_in | input | 8 | Data returned from the RAM |

## Verification
The bench builds the controller with a 5 ns clock at the slowest grade. This gives a 14-cycle read, an 11-cycle minimum strobe, a 6-cycle data setup and a 5-cycle release wait. At that ratio a write issued straight after a read has to stretch its hold-off phase beyond one cycle, so the turnaround wait becomes visible at the pins. The bench's RAM model only presents valid data once the access time has elapsed at the next sampling edge. A read that is one cycle too short therefore returns corrupted data, and each strobe and drive width is measured against the nanosecond limits.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WHOLD,
    ST_WDRIVE
  } ctrl_state_e;

  // RAM access time per speed grade, ns
  function automatic int t_access_ns(input int grade);
    case (grade)
      0:       return 35;
      1:       return 55;
      default: return 70;
    endcase
  endfunction

  // minimum write strobe width, ns
  function automatic int t_strobe_ns(input int grade);
    case (grade)
      0:       return 25;
      1:       return 45;
      default: return 55;
    endcase
  endfunction

  // data valid before strobe end, ns
  function automatic int t_dsetup_ns(input int grade);
    case (grade)
      0:       return 20;
      1:       return 25;
      default: return 30;
    endcase
  endfunction

  // RAM output release after disable, ns
  function automatic int t_release_ns(input int grade);
    case (grade)
      0:       return 15;
      1:       return 20;
      default: return 25;
    endcase
  endfunction

  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_rst_sync.sv
module sram_ctrl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[N-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[N-1];
endmodule

// File: rtl/sram_ctrl_wait.sv
module sram_ctrl_wait #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int RD_CYC  = 4,
  parameter int DRV_CYC = 2,
  parameter int CNT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              hz_done,
  output logic              hz_load,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_ce2,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_LOAD = CNT_W'(DRV_CYC - 1);

  ctrl_state_e state_q, state_d;
  logic              ph_load, ph_done;
  logic [CNT_W-1:0]  ph_val;
  logic              accept, capture;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  sram_ctrl_wait #(.W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .done     (ph_done)
  );

  assign accept  = (state_q == ST_IDLE) && req_valid && rst_n;
  assign capture = (state_q == ST_READ) && ph_done;

  // next state
  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = RD_LOAD;
    hz_load = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (req_write) state_d = ST_WSETUP;
        else begin
          state_d = ST_READ;
          ph_load = 1'b1;
        end
      end
      ST_READ: if (ph_done) begin
        state_d = ST_IDLE;
        hz_load = 1'b1;
      end
      ST_WSETUP: state_d = ST_WHOLD;
      ST_WHOLD: if (hz_done) begin
        state_d = ST_WDRIVE;
        ph_load = 1'b1;
        ph_val  = DRV_LOAD;
      end
      ST_WDRIVE: if (ph_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= capture;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= ram_dq_in;
    end
  end

  assign req_ready  = (state_q == ST_IDLE) && rst_n;
  assign ram_addr   = addr_q;
  assign ram_ce_n   = (state_q == ST_IDLE);
  assign ram_ce2    = (state_q != ST_IDLE);
  assign ram_oe_n   = (state_q != ST_READ);
  assign ram_we_n   = !((state_q == ST_WHOLD) || (state_q == ST_WDRIVE));
  assign ram_dq_oe  = (state_q == ST_WDRIVE);
  assign ram_dq_out = wdata_q;
  assign rd_valid   = rvalid_q;
  assign rd_data    = rdata_q;

  // checks
  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && !ram_ce2 && ram_we_n && ram_oe_n && !ram_dq_oe));
  assert_select_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce_n |-> !ram_ce2);
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_rd_at_oe_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(ram_oe_n));
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));
  assert_drive_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (!ram_we_n && $past(!ram_we_n)));
  assert_drive_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> !ram_dq_oe);
  assert_oe_off_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n);
  assert_drive_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> hz_done);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0,
  parameter int RST_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_ce2,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam int RD_CYC  = ns_to_cyc(t_access_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int WP_CYC  = ns_to_cyc(t_strobe_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int DW_CYC  = ns_to_cyc(t_dsetup_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int HZ_CYC  = ns_to_cyc(t_release_ns(SPEED_GRADE), CLK_PERIOD_NS);
  // hold-off phase is at least one cycle, drive phase covers the rest
  localparam int DRV_CYC = max2(DW_CYC, WP_CYC - 1);
  localparam int CNT_W   = $clog2(max2(max2(RD_CYC, DRV_CYC), HZ_CYC) + 1);
  localparam logic [CNT_W-1:0] HZ_LOAD = CNT_W'(HZ_CYC - 1);

  logic rst_n_s;
  logic hz_load, hz_done;

  sram_ctrl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // bus turnaround wait after a read
  sram_ctrl_wait #(.W(CNT_W)) u_turn (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (hz_load),
    .load_val (HZ_LOAD),
    .done     (hz_done)
  );

  sram_ctrl_fsm #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RD_CYC  (RD_CYC),
    .DRV_CYC (DRV_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .hz_done    (hz_done),
    .hz_load    (hz_load),
    .ram_addr   (ram_addr),
    .ram_ce_n   (ram_ce_n),
    .ram_ce2    (ram_ce2),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe),
    .ram_dq_in  (ram_dq_in)
  );
endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/100ps
module tb_sram_ctrl;
  localparam int CLK_NS = 5;
  localparam int GRADE  = 2;
  localparam int AW = 17;
  localparam int DW = 8;
  // limits for grade 2, ns
  localparam int T_ACC = 70;
  localparam int T_WP  = 55;
  localparam int T_DS  = 30;
  localparam int T_HZ  = 25;
  localparam int RD_EXP = (T_ACC + CLK_NS - 1) / CLK_NS;
  localparam realtime HALF = CLK_NS / 2.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] ram_addr;
  logic ram_ce_n, ram_ce2, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [DW-1:0] ram_dq_out;
  logic [DW-1:0] ram_dq_in = '0;

  int total = 0, bad = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  logic [DW-1:0] ram_mem [int];
  logic [DW-1:0] exp_mem [int];
  logic [DW-1:0] exp_q [$];
  int reads_issued = 0, reads_seen = 0;

  always #(HALF) clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(GRADE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_ce2(ram_ce2), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [DW-1:0] mem_at(input int a);
    return ram_mem.exists(a) ? ram_mem[a] : '0;
  endfunction

  // RAM model: data is valid only once the access time has passed by the next sampling edge
  wire rd_sel = !ram_ce_n && ram_ce2 && !ram_oe_n && ram_we_n;
  realtime rd_start = 0;
  always @(rd_sel or ram_addr) rd_start = $realtime;
  always @(negedge clk) begin
    if (rd_sel && (($realtime + HALF - rd_start) >= T_ACC)) ram_dq_in <= mem_at(int'(ram_addr));
    else ram_dq_in <= mem_at(int'(ram_addr)) ^ 8'hFF;
  end

  // pin monitor
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_drv = 1'b0;
  int we_cnt = 0, drv_cnt = 0, rd_cnt = 0, since_oe = 1000;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] last_dq;
  always @(negedge clk) begin
    if (mon_en) begin
      // R2: idle pins and paired selects
      if (req_ready)
        check(ram_ce_n && !ram_ce2 && ram_we_n && ram_oe_n && !ram_dq_oe, "R2 idle pins", 0, 1);
      check(ram_ce_n == !ram_ce2, "R2 select pair", ram_ce2, !ram_ce_n);
      // R8
      if (!ram_we_n) check(ram_oe_n, "R8 oe during write", ram_oe_n, 1);
      // R9 turnaround
      if (!prev_oe && ram_oe_n) since_oe = 0;
      else if (since_oe < 1000) since_oe++;
      if (!prev_drv && ram_dq_oe)
        check(since_oe * CLK_NS >= T_HZ, "R9 turnaround ns", since_oe * CLK_NS, T_HZ);
      // R3 read window
      if (!ram_oe_n) begin
        check(!ram_ce_n && ram_ce2 && ram_we_n, "R3 read pins", {ram_ce_n, ram_ce2, ram_we_n}, 3'b011);
        rd_cnt++;
      end
      if (!prev_oe && ram_oe_n) begin
        check(rd_cnt == RD_EXP, "R3 read cycles", rd_cnt, RD_EXP);
        check(rd_valid, "R4 valid at oe rise", rd_valid, 1);
        rd_cnt = 0;
      end
      // R5/R6/R7 write strobe
      if (!ram_we_n) begin
        if (prev_we) begin
          wr_addr = ram_addr;
          check(!ram_dq_oe, "R7 no drive first cycle", ram_dq_oe, 0);
        end
        check(ram_addr == wr_addr, "R6 addr stable", ram_addr, wr_addr);
        check(!ram_ce_n && ram_ce2, "R5 selected", ram_ce_n, 0);
        we_cnt++;
        if (ram_dq_oe) drv_cnt++;
        last_dq = ram_dq_out;
      end else begin
        check(!ram_dq_oe, "R7 drive outside strobe", ram_dq_oe, 0);
        if (!prev_we) begin
          check(we_cnt * CLK_NS >= T_WP, "R5 strobe ns", we_cnt * CLK_NS, T_WP);
          check(drv_cnt * CLK_NS >= T_DS, "R7 drive ns", drv_cnt * CLK_NS, T_DS);
          ram_mem[int'(wr_addr)] = last_dq;
          we_cnt = 0;
          drv_cnt = 0;
        end
      end
      // R4 scoreboard
      if (rd_valid) begin
        reads_seen++;
        if (exp_q.size() == 0) check(0, "R4 unexpected read", rd_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R4 read data", rd_data, e);
        end
      end
      prev_we  = ram_we_n;
      prev_oe  = ram_oe_n;
      prev_drv = ram_dq_oe;
    end
  end

  // driver
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // R10: scramble inputs after acceptance
    req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_mem[int'(a)] = d;
    issue(1'b1, a, d);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    exp_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : '0);
    reads_issued++;
    issue(1'b0, a, 8'h00);
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(ram_ce_n && !ram_ce2 && ram_we_n && ram_oe_n && !ram_dq_oe,
          "R1 reset pins", {ram_ce_n, ram_ce2, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
    check(!req_ready && !rd_valid, "R1 ready low in reset", req_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe, "R1 pins after release", ram_ce_n, 1);
    repeat (3) @(negedge clk);
    check(req_ready, "R1 ready after release", req_ready, 1);
    mon_en = 1'b1;

    do_write(17'h00000, 8'h00);
    do_write(17'h1FFFF, 8'hFF);
    do_write(17'h0AAAA, 8'h5A);
    do_write(17'h15555, 8'hA5);
    do_read(17'h1FFFF);
    do_read(17'h00000);
    // read immediately followed by write: turnaround stretch (R9)
    do_read(17'h0AAAA);
    do_write(17'h0AAAA, 8'h3C);
    do_read(17'h0AAAA);
    do_read(17'h15555);
    do_write(17'h01234, 8'h81);
    do_read(17'h01234);
    do_read(17'h01234);
    // R10: inputs scrambled after each acceptance, so only captured values count
    do_write(17'h1FFFF, 8'h7E);
    do_read(17'h1FFFF);
    do_read(17'h00000);
    wait_idle();
    check(reads_seen == reads_issued, "R4 read count", reads_seen, reads_issued);
    check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule